// File: doc/BRIEF.md
# Split-IQ Wideband Input Packer

This block sits in front of two up-conversion channels and lets them act as one wideband channel. When split mode is on, every channel request cycle takes in two consecutive complex samples. The block rebuilds them as two pseudo-complex words. The first channel gets the two in-phase values: sample 0 as its real part and sample 1 as its imaginary part. The second channel gets the two quadrature values in the same way. Each channel then handles only one half of the signal, at twice the normal sample rate.

The block also sets up the second channel for this use. In split mode it forces that channel's phase offset to a quarter turn. It blocks the resampler enable, because the resampler cannot deliver two samples per request. It also judges whether the programmed CIC interpolation factor is legal, and the lower limit is relaxed in split mode.

When split mode is off, the block is transparent. Sample 0 goes to the first channel and sample 1 to the second. The second channel keeps its programmed phase, and the resampler enable passes through. A word is taken only in a cycle where the channels request data and the source has data valid. Both packed words then appear one clock later, marked by one shared valid.

Top module: `splitiq_packer`

## Requirements
- R1: While reset is low, and on the first clock after it rises, `out_valid` is 0 and all four channel outputs are 0.
- R2: `in_take` is high exactly in cycles where `chan_req` and `in_valid` are both 1. `out_valid` is high in the cycle after such a cycle, and low in the cycle after any other cycle.
- R3: A word taken with `split_en`=1 gives `cha_re` = sample 0 real part and `cha_im` = sample 1 real part.
- R4: A word taken with `split_en`=1 gives `chb_re` = sample 0 imaginary part and `chb_im` = sample 1 imaginary part.
- R5: While `split_en`=1, `phase_b` equals 2^(PW-2), which is 0x4000 for PW=16 (a 90 degree turn).
- R6: A word taken with `split_en`=0 gives channel A = sample 0 (re, im) and channel B = sample 1 (re, im). In that mode `phase_b` equals `phase_prog`.
- R7: `resamp_en` is 0 while `split_en`=1, whatever `resamp_req` is. Otherwise it equals `resamp_req`.
- R8: `interp_ok` is 1 exactly when `interp_n` is between a lower bound and 1448, both ends included. The lower bound is 4 when `split_en`=1 and 8 otherwise.
- R9: In a cycle following a cycle with no take, the four channel outputs keep their previous values.
- R10: The packing of a word depends on the value `split_en` had in the cycle that word was taken, so the mode can change from one word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_en | input | 1 | 1 selects split (wideband) mode |
| resamp_req | input | 1 | Requested resampler enable |
| phase_prog | input | PW | Programmed phase offset of the second channel |
| interp_n | input | NW | Programmed CIC interpolation factor |
| chan_req | input | 1 | Channels ask for a new input word |
| in_valid | input | 1 | Source holds a valid pair of samples |
| s0_re | input | DW | Sample 0 real (I0) |
| s0_im | input | DW | Sample 0 imaginary (Q0) |
| s1_re | input | DW | Sample 1 real (I1) |
| s1_im | input | DW | Sample 1 imaginary (Q1) |
| in_take | output | 1 | Input pair taken this cycle |
| out_valid | output | 1 | Shared valid for both channel words |
| cha_re | output | DW | Channel A word, real part |
| cha_im | output | DW | Channel A word, imaginary part |
| chb_re | output | DW | Channel B word, real part |
| chb_im | output | DW | Channel B word, imaginary part |
| phase_b | output | PW | Phase offset applied to channel B |
| resamp_en | output | 1 | Resampler enable after gating |
| interp_ok | output | 1 | Interpolation factor is legal for the current mode |

## Verification
If the packing selection is wrong, the I and Q halves show up swapped or mixed on the channel outputs. This is visible in the cycle right after the take. If the mode is read at the wrong time, only a word taken on a mode change comes out packed the wrong way, so the tests change the mode between back-to-back takes. A bad valid or hold condition shows as a valid pulse or an output change one cycle after a cycle that had only one of the two handshake signals. The phase offset, the resampler gate and the interpolation check are combinational, so a fault in any of them appears in the same cycle as the mode or setting that triggers it.

// File: rtl/splitiq_pkg.sv
package splitiq_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_SPLIT = 1'b1} siq_mode_e;

  localparam int unsigned MIN_N_NORMAL = 8;
  localparam int unsigned MIN_N_SPLIT  = 4;

  function automatic int unsigned min_interp(input siq_mode_e m);
    return (m == MODE_SPLIT) ? MIN_N_SPLIT : MIN_N_NORMAL;
  endfunction

  // quarter of a full phase turn for a pw-bit phase word
  function automatic logic [31:0] quarter_turn(input int unsigned pw);
    return 32'd1 << (pw - 2);
  endfunction
endpackage

// File: rtl/siq_pack.sv
module siq_pack
  import splitiq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  siq_mode_e         mode,
  input  logic [DW-1:0]     s0_re,
  input  logic [DW-1:0]     s0_im,
  input  logic [DW-1:0]     s1_re,
  input  logic [DW-1:0]     s1_im,
  output logic [DW-1:0]     a_re,
  output logic [DW-1:0]     a_im,
  output logic [DW-1:0]     b_re,
  output logic [DW-1:0]     b_im
);
  always_comb begin
    if (mode == MODE_SPLIT) begin
      a_re = s0_re;
      a_im = s1_re;
      b_re = s0_im;
      b_im = s1_im;
    end else begin
      a_re = s0_re;
      a_im = s0_im;
      b_re = s1_re;
      b_im = s1_im;
    end
  end
endmodule

// File: rtl/siq_cfg.sv
module siq_cfg
  import splitiq_pkg::*;
#(
  parameter int unsigned PW   = 16,
  parameter int unsigned NW   = 11,
  parameter int unsigned NMAX = 1448
) (
  input  logic          clk,
  input  logic          rst_n,
  input  siq_mode_e     mode,
  input  logic          resamp_req,
  input  logic [PW-1:0] phase_prog,
  input  logic [NW-1:0] interp_n,
  output logic [PW-1:0] phase_b,
  output logic          resamp_en,
  output logic          interp_ok
);
  localparam logic [31:0] QUARTER32 = quarter_turn(PW);
  localparam logic [PW-1:0] QUARTER = QUARTER32[PW-1:0];

  logic [31:0] n_ext;
  logic [31:0] n_lo;
  logic        lo_pass;
  logic        hi_pass;

  assign n_ext   = 32'(interp_n);
  assign n_lo    = 32'(min_interp(mode));
  assign lo_pass = n_ext >= n_lo;
  assign hi_pass = n_ext <= 32'(NMAX);

  assign phase_b   = (mode == MODE_SPLIT) ? QUARTER : phase_prog;
  assign resamp_en = resamp_req & (mode != MODE_SPLIT);
  assign interp_ok = lo_pass & hi_pass;

  // R7
  resamp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT) |-> !resamp_en);

  // R8
  interp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interp_ok |-> (interp_n >= NW'(4)));
endmodule

// File: rtl/siq_stage.sv
module siq_stage
  import splitiq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] a_re_d,
  input  logic [DW-1:0] a_im_d,
  input  logic [DW-1:0] b_re_d,
  input  logic [DW-1:0] b_im_d,
  output logic          vld_q,
  output logic [DW-1:0] a_re_q,
  output logic [DW-1:0] a_im_q,
  output logic [DW-1:0] b_re_q,
  output logic [DW-1:0] b_im_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      a_re_q <= '0;
      a_im_q <= '0;
      b_re_q <= '0;
      b_im_q <= '0;
    end else begin
      vld_q <= take;
      if (take) begin
        a_re_q <= a_re_d;
        a_im_q <= a_im_d;
        b_re_q <= b_re_d;
        b_im_q <= b_im_d;
      end
    end
  end

  // R2
  valid_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vld_q);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !vld_q);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(a_re_q) && $stable(a_im_q) && $stable(b_re_q) && $stable(b_im_q)));
endmodule

// File: rtl/splitiq_packer.sv
module splitiq_packer
  import splitiq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned PW   = 16,
  parameter int unsigned NW   = 11,
  parameter int unsigned NMAX = 1448
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split_en,
  input  logic          resamp_req,
  input  logic [PW-1:0] phase_prog,
  input  logic [NW-1:0] interp_n,
  input  logic          chan_req,
  input  logic          in_valid,
  input  logic [DW-1:0] s0_re,
  input  logic [DW-1:0] s0_im,
  input  logic [DW-1:0] s1_re,
  input  logic [DW-1:0] s1_im,
  output logic          in_take,
  output logic          out_valid,
  output logic [DW-1:0] cha_re,
  output logic [DW-1:0] cha_im,
  output logic [DW-1:0] chb_re,
  output logic [DW-1:0] chb_im,
  output logic [PW-1:0] phase_b,
  output logic          resamp_en,
  output logic          interp_ok
);
  siq_mode_e     mode;
  logic          take_evt;
  logic [DW-1:0] pk_a_re, pk_a_im, pk_b_re, pk_b_im;

  assign mode     = split_en ? MODE_SPLIT : MODE_NORMAL;
  assign take_evt = chan_req & in_valid;
  assign in_take  = take_evt;

  siq_pack #(.DW(DW)) u_pack (
    .mode (mode),
    .s0_re(s0_re), .s0_im(s0_im), .s1_re(s1_re), .s1_im(s1_im),
    .a_re (pk_a_re), .a_im(pk_a_im), .b_re(pk_b_re), .b_im(pk_b_im)
  );

  siq_stage #(.DW(DW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take_evt),
    .a_re_d(pk_a_re), .a_im_d(pk_a_im), .b_re_d(pk_b_re), .b_im_d(pk_b_im),
    .vld_q (out_valid),
    .a_re_q(cha_re), .a_im_q(cha_im), .b_re_q(chb_re), .b_im_q(chb_im)
  );

  siq_cfg #(.PW(PW), .NW(NW), .NMAX(NMAX)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .resamp_req(resamp_req),
    .phase_prog(phase_prog),
    .interp_n  (interp_n),
    .phase_b   (phase_b),
    .resamp_en (resamp_en),
    .interp_ok (interp_ok)
  );

  // R3
  split_a_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && split_en) |=> (cha_re == $past(s0_re) && cha_im == $past(s1_re)));

  // R4
  split_b_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && split_en) |=> (chb_re == $past(s0_im) && chb_im == $past(s1_im)));

  // R6
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !split_en) |=> (cha_im == $past(s0_im) && chb_re == $past(s1_re)));
endmodule

// File: tb/sim_splitiq_packer.sv
module sim_splitiq_packer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int PW = 16;
  localparam int NW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          split_en = 1'b0, resamp_req = 1'b0;
  logic [PW-1:0] phase_prog = '0;
  logic [NW-1:0] interp_n = '0;
  logic          chan_req = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] s0_re = '0, s0_im = '0, s1_re = '0, s1_im = '0;
  logic          in_take, out_valid, resamp_en, interp_ok;
  logic [DW-1:0] cha_re, cha_im, chb_re, chb_im;
  logic [PW-1:0] phase_b;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  splitiq_packer u0 (
    .clk(clk), .rst_n(rst_n), .split_en(split_en), .resamp_req(resamp_req),
    .phase_prog(phase_prog), .interp_n(interp_n), .chan_req(chan_req),
    .in_valid(in_valid), .s0_re(s0_re), .s0_im(s0_im), .s1_re(s1_re),
    .s1_im(s1_im), .in_take(in_take), .out_valid(out_valid),
    .cha_re(cha_re), .cha_im(cha_im), .chb_re(chb_re), .chb_im(chb_im),
    .phase_b(phase_b), .resamp_en(resamp_en), .interp_ok(interp_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; results read at the next falling edge
  task automatic drive(input logic req, input logic vld,
                       input logic [DW-1:0] a, b, c, d);
    chan_req = req; in_valid = vld;
    s0_re = a; s0_im = b; s1_re = c; s1_im = d;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_words(input string req, input logic [DW-1:0] ar, ai, br, bi);
    chk({req, " cha_re"}, 32'(cha_re), 32'(ar));
    chk({req, " cha_im"}, 32'(cha_im), 32'(ai));
    chk({req, " chb_re"}, 32'(chb_re), 32'(br));
    chk({req, " chb_im"}, 32'(chb_im), 32'(bi));
  endtask

  task automatic t_reset();
    step();
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk_words("R1", '0, '0, '0, '0);
    rst_n = 1'b1;
    step();
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
  endtask

  task automatic t_split_pack();
    split_en = 1'b1;
    drive(1, 1, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    #1 chk("R2 take", 32'(in_take), 32'd1);
    step();
    drive(0, 0, '0, '0, '0, '0);
    chk("R2 valid after take", 32'(out_valid), 32'd1);
    chk("R3 cha_re", 32'(cha_re), 32'h1111);
    chk("R3 cha_im", 32'(cha_im), 32'h3333);
    chk("R4 chb_re", 32'(chb_re), 32'h2222);
    chk("R4 chb_im", 32'(chb_im), 32'h4444);
    phase_prog = 16'h1234;
    #1 chk("R5 phase quarter", 32'(phase_b), 32'h4000);
    step();
    chk("R2 valid single pulse", 32'(out_valid), 32'd0);
  endtask

  task automatic t_normal();
    split_en = 1'b0;
    phase_prog = 16'h0abc;
    drive(1, 1, 16'hA001, 16'hB002, 16'hC003, 16'hD004);
    step();
    drive(0, 0, '0, '0, '0, '0);
    chk("R6 valid", 32'(out_valid), 32'd1);
    chk_words("R6", 16'hA001, 16'hB002, 16'hC003, 16'hD004);
    chk("R6 phase programmed", 32'(phase_b), 32'h0abc);
  endtask

  task automatic t_half_handshake();
    split_en = 1'b1;
    drive(1, 0, 16'h5555, 16'h6666, 16'h7777, 16'h8888);
    #1 chk("R2 no take req only", 32'(in_take), 32'd0);
    step();
    chk("R2 no valid req only", 32'(out_valid), 32'd0);
    chk_words("R9 hold req only", 16'hA001, 16'hB002, 16'hC003, 16'hD004);
    drive(0, 1, 16'h5555, 16'h6666, 16'h7777, 16'h8888);
    #1 chk("R2 no take valid only", 32'(in_take), 32'd0);
    step();
    chk("R2 no valid valid only", 32'(out_valid), 32'd0);
    chk_words("R9 hold valid only", 16'hA001, 16'hB002, 16'hC003, 16'hD004);
    drive(0, 0, '0, '0, '0, '0);
  endtask

  task automatic t_mode_switch();
    split_en = 1'b1;
    drive(1, 1, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
    step();
    split_en = 1'b0;
    drive(1, 1, 16'h0505, 16'h0606, 16'h0707, 16'h0808);
    chk("R10 valid first", 32'(out_valid), 32'd1);
    chk_words("R10 split word", 16'h0101, 16'h0303, 16'h0202, 16'h0404);
    step();
    drive(0, 0, '0, '0, '0, '0);
    chk("R10 valid second", 32'(out_valid), 32'd1);
    chk_words("R10 normal word", 16'h0505, 16'h0606, 16'h0707, 16'h0808);
    step();
  endtask

  task automatic t_resamp();
    resamp_req = 1'b1; split_en = 1'b1;
    #1 chk("R7 blocked in split", 32'(resamp_en), 32'd0);
    split_en = 1'b0;
    #1 chk("R7 pass in normal", 32'(resamp_en), 32'd1);
    resamp_req = 1'b0;
    #1 chk("R7 pass low", 32'(resamp_en), 32'd0);
    step();
  endtask

  task automatic t_interp();
    split_en = 1'b1;
    interp_n = 11'd3;    #1 chk("R8 split 3", 32'(interp_ok), 32'd0);
    interp_n = 11'd4;    #1 chk("R8 split 4", 32'(interp_ok), 32'd1);
    interp_n = 11'd1448; #1 chk("R8 split 1448", 32'(interp_ok), 32'd1);
    interp_n = 11'd1449; #1 chk("R8 split 1449", 32'(interp_ok), 32'd0);
    split_en = 1'b0;
    interp_n = 11'd4;    #1 chk("R8 normal 4", 32'(interp_ok), 32'd0);
    interp_n = 11'd7;    #1 chk("R8 normal 7", 32'(interp_ok), 32'd0);
    interp_n = 11'd8;    #1 chk("R8 normal 8", 32'(interp_ok), 32'd1);
    interp_n = 11'd1448; #1 chk("R8 normal 1448", 32'(interp_ok), 32'd1);
    interp_n = 11'd2047; #1 chk("R8 normal 2047", 32'(interp_ok), 32'd0);
    interp_n = 11'd0;
    step();
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_split_pack();
    t_normal();
    t_half_handshake();
    t_mode_switch();
    t_resamp();
    t_interp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule